// File: doc/BRIEF.md
# Delay-Feedback Pipeline FFT Butterfly Stage

This block is one butterfly stage for a 64-point pipelined FFT that uses the radix-2^2 decomposition with a single data path and delay feedback. It accepts one complex sample per clock and returns one complex sample per clock. A feedback buffer of `DELAY` words holds samples until their partners arrive. An adder/subtractor butterfly with multiplexed routing combines each held sample with the matching incoming one. The butterfly contains no multiplier. The six stages of a 64-point pipeline use delays of 32, 16, 8, 4, 2 and 1.

The stage is sequenced by two bits taken from a sample counter that is shared across the pipeline and kept outside the block. `ctlSel` chooses between the fill phase and the butterfly phase. With `SECOND_STAGE` set, `ctlRot` together with `ctlSel` enables a multiply by -j on the incoming sample. That rotation needs only a swap of the real and imaginary parts and one negation.

The feedback buffer is a register file. It is read and written at a single wrapping pointer, so one location changes per clock and no data moves along a chain of registers. Each stage widens the word by exactly one bit. `start` marks the first sample of a new stream. `inValid` qualifies every sample, and gaps in the stream are allowed.

Top module: `sdf_bfly_stage`

## Requirements
- R1: While `rstN` is low, and after it is released until the first valid input, `outValid` is 0 and `outRe`/`outIm` are 0; the feedback buffer also holds zeros.
- R2: For a valid input with `ctlSel`=0, the incoming sample is stored at the pointer location. On the next clock the output becomes the word that was stored at that location `DELAY` valid inputs earlier, unchanged.
- R3: For a valid input with `ctlSel`=1, the output on the next clock is the stored word plus the (possibly rotated) incoming sample. The stored word minus the incoming sample replaces it in the buffer and emerges `DELAY` valid inputs later.
- R4: Outputs are `IN_W+1` bits signed two's complement. When `ctlSel` follows counter bit log2(`DELAY`), full-scale inputs (-2^(IN_W-1) and 2^(IN_W-1)-1) produce exact results with no wrap-around.
- R5: With `SECOND_STAGE`=1, a valid input with `ctlSel`=1 and `ctlRot`=1 is first replaced by (re,im) -> (im, -re), which is a multiply by -j. With any other pair of control bit values the sample is not rotated.
- R6: With `SECOND_STAGE`=0, `ctlRot` has no effect on any output.
- R7: `outValid` is 1 on the output produced by the valid input whose index since the last start is `DELAY` or higher (the first sample has index 0). It is 0 for outputs from lower indices.
- R8: A clock with `inValid`=0 changes nothing: outputs, `outValid`, the pointer and the buffer all hold. `start` and the control bits are ignored on such a clock.
- R9: A valid input with `start`=1 is stored at pointer location 0 and restarts the index count of R7 from 0.
- R10: The pointer advances by one on each valid input and wraps from `DELAY`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | First sample of a new stream; qualified by `inValid` |
| inValid | input | 1 | Incoming sample is valid this cycle |
| ctlSel | input | 1 | Counter bit choosing fill (0) or butterfly (1) phase |
| ctlRot | input | 1 | Counter bit that, with `ctlSel`, enables -j in second-stage mode |
| inRe | input | IN_W | Incoming real part, signed |
| inIm | input | IN_W | Incoming imaginary part, signed |
| outValid | output | 1 | Output sample is valid |
| outRe | output | IN_W+1 | Output real part, signed |
| outIm | output | IN_W+1 | Output imaginary part, signed |

## Verification
The bench builds two copies of the stage with a 10-bit input. One is a second-stage variant with `DELAY`=4, and the other is a first-stage variant with `DELAY`=2. The short delays make pointer wrap, restarts in the middle of a stream and the validity threshold happen many times within a few hundred samples. They also let the rotating and non-rotating control quarters cycle often. Driving both copies from one bench counter checks that `ctlRot` produces a -j only in the second-stage variant, and that full-scale streams stay exact in both widths.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  // Strobes passed from the stage control to its datapath each clock.
  typedef struct packed {
    logic wrEn;    // accept the incoming sample and advance state
    logic useSum;  // butterfly phase: add to output, subtract into buffer
    logic rotate;  // apply the -j rotation to the incoming sample
  } sdfStrobe_t;

  function automatic int unsigned addrWidth(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl
  import sdf_pkg::*;
#(
  parameter int unsigned DELAY        = 32,
  parameter bit          SECOND_STAGE = 1'b0
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               start,
  input  logic                               inValid,
  input  logic                               ctlSel,
  input  logic                               ctlRot,
  output sdfStrobe_t                         strobe,
  output logic [addrWidth(DELAY)-1:0]        rdWrAddr,
  output logic                               outValid
);

  localparam int unsigned AW = addrWidth(DELAY);
  localparam int unsigned FW = $clog2(DELAY + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DELAY - 1);
  localparam logic [FW-1:0] FILL_MAX  = FW'(DELAY);

  logic [AW-1:0] ptr;
  logic [AW-1:0] ptrCur;
  logic [AW-1:0] ptrNext;
  logic [FW-1:0] fill;
  logic [FW-1:0] fillCur;
  logic          fillFull;

  // A qualified start restarts the pointer and the fill count at once.
  always_comb begin
    ptrCur   = start ? '0 : ptr;
    fillCur  = start ? '0 : fill;
    fillFull = (fillCur == FILL_MAX);
    ptrNext  = (ptrCur == LAST_ADDR) ? '0 : ptrCur + AW'(1);
  end

  generate
    if (SECOND_STAGE) begin : g_rot
      assign strobe.rotate = inValid && ctlSel && ctlRot;
    end else begin : g_norot
      assign strobe.rotate = 1'b0;
    end
  endgenerate

  assign strobe.wrEn   = inValid;
  assign strobe.useSum = ctlSel;
  assign rdWrAddr      = ptrCur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr      <= '0;
      fill     <= '0;
      outValid <= 1'b0;
    end else if (inValid) begin
      ptr      <= ptrNext;
      fill     <= fillFull ? fillCur : fillCur + FW'(1);
      outValid <= fillFull;
    end
  end

  // R10: the pointer stays inside the buffer
  a_r10_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= LAST_ADDR);

  // R10: wrap from the last location back to zero
  a_r10_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !start && ptr == LAST_ADDR) |=> (ptr == '0));

  // R9: a qualified start stores at zero, so the pointer then sits one past it
  a_r9_start_restart: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && start) |=> (ptr == ((DELAY > 1) ? AW'(1) : AW'(0))) && (fill == FW'(1)));

  // R8: an idle clock leaves the control state untouched
  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(ptr) && $stable(fill) && $stable(outValid));

  // R7: validity only rises on a clock that accepted a sample
  a_r7_valid_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(inValid));

endmodule

// File: rtl/sdf_datapath.sv
module sdf_datapath
  import sdf_pkg::*;
#(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned DELAY = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  sdfStrobe_t                         strobe,
  input  logic [addrWidth(DELAY)-1:0]        rdWrAddr,
  input  logic signed [IN_W-1:0]             inRe,
  input  logic signed [IN_W-1:0]             inIm,
  output logic signed [IN_W:0]               outRe,
  output logic signed [IN_W:0]               outIm
);

  localparam int unsigned OW = IN_W + 1;

  logic signed [OW-1:0] bufRe [DELAY];
  logic signed [OW-1:0] bufIm [DELAY];

  logic signed [OW-1:0] extRe, extIm;
  logic signed [OW-1:0] xRe, xIm;
  logic signed [OW-1:0] heldRe, heldIm;
  logic signed [OW-1:0] nextOutRe, nextOutIm;
  logic signed [OW-1:0] backRe, backIm;

  always_comb begin
    extRe = {inRe[IN_W-1], inRe};
    extIm = {inIm[IN_W-1], inIm};
    // -j rotation: swap parts, negate the new imaginary part
    if (strobe.rotate) begin
      xRe = extIm;
      xIm = -extRe;
    end else begin
      xRe = extRe;
      xIm = extIm;
    end
    heldRe = bufRe[rdWrAddr];
    heldIm = bufIm[rdWrAddr];
    if (strobe.useSum) begin
      nextOutRe = heldRe + xRe;
      nextOutIm = heldIm + xIm;
      backRe    = heldRe - xRe;
      backIm    = heldIm - xIm;
    end else begin
      nextOutRe = heldRe;
      nextOutIm = heldIm;
      backRe    = xRe;
      backIm    = xIm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(DELAY); i++) begin
        bufRe[i] <= '0;
        bufIm[i] <= '0;
      end
    end else if (strobe.wrEn) begin
      bufRe[rdWrAddr] <= backRe;
      bufIm[rdWrAddr] <= backIm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outRe <= '0;
      outIm <= '0;
    end else if (strobe.wrEn) begin
      outRe <= nextOutRe;
      outIm <= nextOutIm;
    end
  end

  // R8: outputs hold across an idle clock
  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrEn |=> $stable(outRe) && $stable(outIm));

  // R2: in the fill phase the output is exactly the word read from the buffer
  a_r2_pass_through: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !strobe.useSum) |=> (outRe == $past(heldRe)) && (outIm == $past(heldIm)));

endmodule

// File: rtl/sdf_bfly_stage.sv
module sdf_bfly_stage
  import sdf_pkg::*;
#(
  parameter int unsigned IN_W         = 10,
  parameter int unsigned DELAY        = 32,
  parameter bit          SECOND_STAGE = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  inValid,
  input  logic                  ctlSel,
  input  logic                  ctlRot,
  input  logic signed [IN_W-1:0] inRe,
  input  logic signed [IN_W-1:0] inIm,
  output logic                  outValid,
  output logic signed [IN_W:0]  outRe,
  output logic signed [IN_W:0]  outIm
);

  localparam int unsigned AW = addrWidth(DELAY);

  sdfStrobe_t    strobe;
  logic [AW-1:0] rdWrAddr;

  sdf_ctrl #(
    .DELAY        (DELAY),
    .SECOND_STAGE (SECOND_STAGE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .inValid  (inValid),
    .ctlSel   (ctlSel),
    .ctlRot   (ctlRot),
    .strobe   (strobe),
    .rdWrAddr (rdWrAddr),
    .outValid (outValid)
  );

  sdf_datapath #(
    .IN_W  (IN_W),
    .DELAY (DELAY)
  ) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rdWrAddr (rdWrAddr),
    .inRe     (inRe),
    .inIm     (inIm),
    .outRe    (outRe),
    .outIm    (outIm)
  );

  // R6: without second-stage mode no rotation strobe is ever issued
  a_r6_no_rotation: assert property (@(posedge clk) disable iff (!rstN)
    (!SECOND_STAGE) |-> !strobe.rotate);

endmodule

// File: tb/test_sdf_bfly_stage.sv
module test_sdf_bfly_stage;

  localparam int IN_W = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic inValid = 1'b0;
  logic ctlSelA = 1'b0, ctlRotA = 1'b0, ctlSelB = 1'b0, ctlRotB = 1'b0;
  logic signed [IN_W-1:0] inRe = '0, inIm = '0;
  logic outValidA, outValidB;
  logic signed [IN_W:0] outReA, outImA, outReB, outImB;

  always #4 clk = ~clk;  // 125 MHz

  // Instance A: second-stage variant, delay 4 (sel = cnt[2], rot = cnt[3])
  sdf_bfly_stage #(.IN_W(IN_W), .DELAY(4), .SECOND_STAGE(1'b1)) i_sdf_bfly_stage (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .ctlSel(ctlSelA), .ctlRot(ctlRotA), .inRe(inRe), .inIm(inIm),
    .outValid(outValidA), .outRe(outReA), .outIm(outImA));

  // Instance B: first-stage variant, delay 2 (sel = cnt[1], rot = cnt[2])
  sdf_bfly_stage #(.IN_W(IN_W), .DELAY(2), .SECOND_STAGE(1'b0)) i_sdf_bfly_stage_first (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .ctlSel(ctlSelB), .ctlRot(ctlRotB), .inRe(inRe), .inIm(inIm),
    .outValid(outValidB), .outRe(outReB), .outIm(outImB));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int mRe [2][64];
  int mIm [2][64];
  int ptrM [2];
  int fillM [2];
  int eRe [2];
  int eIm [2];
  bit eV [2];
  string tag [2];
  logic [5:0] cnt = '0;

  function automatic int wrap11(input int v);
    logic signed [IN_W:0] t;
    t = v[IN_W:0];
    return int'(t);
  endfunction

  // Behavioural model of one stage, applied on an accepted clock.
  task automatic modelStep(input int k, input int d, input bit second, input bit v,
                           input bit st, input bit sel, input bit rot,
                           input int xr, input int xi);
    int p, f, rr, ri, dr, di;
    bit extreme;
    extreme = (xr == -512) || (xr == 511) || (xi == -512) || (xi == 511);
    if (!v) begin
      tag[k] = st ? "R8 (start ignored)" : "R8";
      return;
    end
    p = st ? 0 : ptrM[k];
    f = st ? 0 : fillM[k];
    rr = xr; ri = xi;
    if (second && sel && rot) begin
      rr = xi; ri = -xr;
    end
    dr = mRe[k][p]; di = mIm[k][p];
    if (sel) begin
      eRe[k] = wrap11(dr + rr); eIm[k] = wrap11(di + ri);
      mRe[k][p] = wrap11(dr - rr); mIm[k][p] = wrap11(di - ri);
    end else begin
      eRe[k] = dr; eIm[k] = di;
      mRe[k][p] = rr; mIm[k][p] = ri;
    end
    eV[k] = (f == d);
    if (st)                          tag[k] = "R9";
    else if (extreme)                tag[k] = "R4";
    else if (second && sel && rot)   tag[k] = "R5";
    else if (!second && sel && rot)  tag[k] = "R6";
    else if (p == d - 1)             tag[k] = "R10";
    else if (sel)                    tag[k] = "R3";
    else                             tag[k] = "R2";
    ptrM[k]  = (p == d - 1) ? 0 : p + 1;
    fillM[k] = (f < d) ? f + 1 : d;
  endtask

  task automatic checkOne(input int k, input int aRe, input int aIm, input bit aV);
    checks++;
    if (aRe != eRe[k] || aIm != eIm[k]) begin
      errors++;
      $display("FAIL %s inst%0d data: got (%0d,%0d) expected (%0d,%0d)",
               tag[k], k, aRe, aIm, eRe[k], eIm[k]);
    end
    checks++;
    if (aV != eV[k]) begin
      errors++;
      $display("FAIL R7 inst%0d outValid: got %0d expected %0d", k, aV, eV[k]);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(input bit st, input bit v, input int xr, input int xi);
    logic [5:0] c;
    c = (st && v) ? 6'd0 : cnt;
    start   = st;
    inValid = v;
    inRe    = xr[IN_W-1:0];
    inIm    = xi[IN_W-1:0];
    ctlSelA = c[2]; ctlRotA = c[3];
    ctlSelB = c[1]; ctlRotB = c[2];
    modelStep(0, 4, 1'b1, v, st, c[2], c[3], xr, xi);
    modelStep(1, 2, 1'b0, v, st, c[1], c[2], xr, xi);
    if (v) cnt = c + 6'd1;
    @(posedge clk);
    @(negedge clk);
    checkOne(0, int'(outReA), int'(outImA), outValidA);
    checkOne(1, int'(outReB), int'(outImB), outValidB);
  endtask

  function automatic int rnd10();
    int r;
    r = int'($urandom_range(0, 9));
    if (r == 0) return -512;
    if (r == 1) return 511;
    return int'($urandom_range(0, 1023)) - 512;
  endfunction

  initial begin
    void'($urandom(32'd20240607));
    for (int k = 0; k < 2; k++) begin
      for (int i = 0; i < 64; i++) begin mRe[k][i] = 0; mIm[k][i] = 0; end
      ptrM[k] = 0; fillM[k] = 0; eRe[k] = 0; eIm[k] = 0; eV[k] = 0; tag[k] = "R1";
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    checkOne(0, int'(outReA), int'(outImA), outValidA);
    checkOne(1, int'(outReB), int'(outImB), outValidB);
    rstN = 1'b1;
    @(negedge clk);
    checkOne(0, int'(outReA), int'(outImA), outValidA);
    checkOne(1, int'(outReB), int'(outImB), outValidB);

    // Directed: small ramp, start of stream, R7 threshold and R2/R3 phases
    step(1'b1, 1'b1, 1, -2);
    for (int i = 1; i < 20; i++) step(1'b0, 1'b1, i * 3, -i);
    // Directed R4: full-scale streams
    step(1'b1, 1'b1, -512, 511);
    for (int i = 0; i < 31; i++) step(1'b0, 1'b1, -512, 511);
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, 511, -512);
    for (int i = 0; i < 32; i++) step(1'b0, 1'b1, (i % 2) ? -512 : 511, (i % 3) ? -512 : 511);
    // Directed R8: idle clocks with start and junk data
    step(1'b1, 1'b0, 77, 88);
    step(1'b0, 1'b0, -5, 5);
    step(1'b0, 1'b1, 9, 9);
    // Constrained random with gaps and occasional restarts
    for (int i = 0; i < 600; i++) begin
      bit v, st;
      v  = ($urandom_range(0, 9) < 8);
      st = ($urandom_range(0, 49) == 0);
      step(st, v, rnd10(), rnd10());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule